// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block owns the program counter of a small 8-bit processor core. Each cycle it looks at the 13-bit instruction word fetched from the current address, together with a skip request from the execute side and the current page selector. From these it decides the next fetch address. The choices are the next word in sequence, a transfer inside the selected page, a full-range transfer spread over two words, or a return taken from its internal return-address stack.

Short transfers take their upper address bits from the page selector and their lower ten bits from the instruction. Long transfers ignore the page selector. Their first word is a prefix that holds the top address bits, and the word after it holds the remaining low bits. Calls of both kinds push a return address onto a circular stack. The return-with-literal instruction pops that stack. Instruction memory and data-path arithmetic sit outside the block: the instruction word is expected to reflect `fetch_addr` in the same cycle.

Top module: `pseq_top`

## Requirements
- R1: In the cycle after a cycle with `rst` high, `fetch_addr` is 0 and `stk_ovf` is 0, and the return stack is empty.
- R2: A word that is not a transfer and not skipped advances `fetch_addr` by one in the next cycle.
- R3: A short jump (instr[12:10] = 3'b101) loads `fetch_addr` with {page, instr[9:0]} in the next cycle and pushes nothing.
- R4: A short call (instr[12:10] = 3'b100) loads `fetch_addr` with {page, instr[9:0]} and pushes the call's address plus one.
- R5: A long call (prefix instr[12:4] = 9'h1EA) goes to the second word in the next cycle. In the cycle after that it loads `fetch_addr` with {prefix instr[3:0], second word[8:0]}, ignores `page`, and pushes the second word's address plus one.
- R6: A return-with-literal word (instr[12:8] = 5'b11100) loads `fetch_addr` with the most recently pushed, not yet popped, address and pops it.
- R7: A long jump (prefix instr[12:4] = 9'h1EB) forms its target the same way as a long call and pushes nothing.
- R8: When `skip_req` is high with a word that is not a long prefix, that word has no effect and `fetch_addr` advances by one.
- R9: When `skip_req` is high with a long prefix, both the prefix and its second word are skipped and `fetch_addr` advances by two.
- R10: `skip_req` is ignored while the second word of a long transfer is presented.
- R11: The stack holds 8 entries and wraps circularly. A push while 8 entries are held overwrites the oldest entry and sets `stk_ovf`. The flag then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 13 | Instruction word at the current fetch address |
| skip_req | input | 1 | Discard the current word (and a long transfer's second word) |
| page | input | 3 | Page selector for short transfers |
| fetch_addr | output | 13 | Registered program counter |
| stk_ovf | output | 1 | Sticky return-stack overflow flag |

## Verification
The bench builds the block with its default page width of 3 bits and a stack depth of 8. With these values, nine nested short calls fill the stack and then push once more. This shows the overflow flag staying low through the eighth push and rising on the ninth. It also shows that the newest return address survives the wrap. Page values near the top of the 3-bit range, and long targets that fill the prefix nibble, test that the upper address bits come from the right source.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int INSTR_W = 13;
  localparam int SHORT_W = 10;
  localparam int NIB_W   = 4;

  typedef enum logic [2:0] {
    OP_SEQ,
    OP_CALL,
    OP_JUMP,
    OP_RETL,
    OP_LCALL_PRE,
    OP_LJMP_PRE
  } op_e;
endpackage

// File: rtl/pseq_decode.sv
module pseq_decode
  import pseq_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output op_e                op
);
  always_comb begin
    op = OP_SEQ;
    if (word[12:10] == 3'b100)      op = OP_CALL;
    else if (word[12:10] == 3'b101) op = OP_JUMP;
    else if (word[12:8] == 5'b11100) op = OP_RETL;
    else if (word[12:4] == 9'h1EA)  op = OP_LCALL_PRE;
    else if (word[12:4] == 9'h1EB)  op = OP_LJMP_PRE;
  end
endmodule

// File: rtl/pseq_target.sv
module pseq_target
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic [PAGE_W-1:0]          page,
  input  logic [INSTR_W-1:0]         word,
  input  logic [NIB_W-1:0]           nib,
  output logic [PAGE_W+SHORT_W-1:0]  short_tgt,
  output logic [PAGE_W+SHORT_W-1:0]  long_tgt
);
  localparam int AW    = PAGE_W + SHORT_W;
  localparam int LOW_W = AW - NIB_W;

  always_comb begin
    short_tgt = {page, word[SHORT_W-1:0]};
    long_tgt  = {nib, word[LOW_W-1:0]};
  end
endmodule

// File: rtl/pseq_stack.sv
module pseq_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top_val,
  output logic          ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] sp_top;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign sp_top  = wrap_dec(sp_q);
  assign top_val = mem[sp_top];

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      sp_q <= wrap_inc(sp_q);
      if (cnt_q == CW'(DEPTH)) ovf <= 1'b1;
      else                     cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      sp_q <= sp_top;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [INSTR_W-1:0]         instr,
  input  logic                       skip_req,
  input  logic [PAGE_W-1:0]          page,
  output logic [PAGE_W+SHORT_W-1:0]  fetch_addr,
  output logic                       stk_ovf
);
  localparam int AW = PAGE_W + SHORT_W;

  op_e            op;
  logic [AW-1:0]  pc_q, pc_d, short_tgt, long_tgt, top_val, push_val;
  logic           second_q, second_d, lcall_q, lcall_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic           push, pop, is_pre;

  pseq_decode u_dec (.word(instr), .op(op));

  pseq_target #(.PAGE_W(PAGE_W)) u_tgt (
    .page(page), .word(instr), .nib(nib_q),
    .short_tgt(short_tgt), .long_tgt(long_tgt)
  );

  pseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_val(push_val), .top_val(top_val), .ovf(stk_ovf)
  );

  assign is_pre   = (op == OP_LCALL_PRE) || (op == OP_LJMP_PRE);
  assign push_val = pc_q + 1'b1;

  always_comb begin
    pc_d     = pc_q + 1'b1;
    push     = 1'b0;
    pop      = 1'b0;
    second_d = 1'b0;
    lcall_d  = lcall_q;
    nib_d    = nib_q;
    if (second_q) begin
      pc_d = long_tgt;
      push = lcall_q;
    end else if (skip_req) begin
      pc_d = is_pre ? pc_q + AW'(2) : pc_q + 1'b1;
    end else begin
      case (op)
        OP_CALL: begin
          pc_d = short_tgt;
          push = 1'b1;
        end
        OP_JUMP: pc_d = short_tgt;
        OP_RETL: begin
          pc_d = top_val;
          pop  = 1'b1;
        end
        OP_LCALL_PRE, OP_LJMP_PRE: begin
          second_d = 1'b1;
          lcall_d  = (op == OP_LCALL_PRE);
          nib_d    = instr[NIB_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      second_q <= 1'b0;
      lcall_q  <= 1'b0;
      nib_q    <= '0;
    end else begin
      pc_q     <= pc_d;
      second_q <= second_d;
      lcall_q  <= lcall_d;
      nib_q    <= nib_d;
    end
  end

  assign fetch_addr = pc_q;
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
  parameter int PAGE_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [12:0]           instr,
  input logic                  skip_req,
  input logic [PAGE_W-1:0]     page,
  input logic [PAGE_W+9:0]     fetch_addr,
  input logic                  stk_ovf,
  input logic                  second_q
);
  localparam int AW = PAGE_W + 10;

  logic is_pre;
  assign is_pre = (instr[12:5] == 8'hF5);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0 && !stk_ovf));

  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (!second_q && !skip_req && instr[12] == 1'b0) |=> fetch_addr == $past(fetch_addr) + AW'(1));

  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (!second_q && !skip_req && instr[12:10] == 3'b101)
      |=> fetch_addr == {$past(page), $past(instr[9:0])});

  assert_call_R4: assert property (@(posedge clk) disable iff (rst)
    (!second_q && !skip_req && instr[12:10] == 3'b100)
      |=> fetch_addr == {$past(page), $past(instr[9:0])});

  assert_skip_one_R8: assert property (@(posedge clk) disable iff (rst)
    (!second_q && skip_req && !is_pre) |=> fetch_addr == $past(fetch_addr) + AW'(1));

  assert_skip_two_R9: assert property (@(posedge clk) disable iff (rst)
    (!second_q && skip_req && is_pre) |=> fetch_addr == $past(fetch_addr) + AW'(2));

  assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);
endmodule

bind pseq_top pseq_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .skip_req(skip_req), .page(page),
  .fetch_addr(fetch_addr), .stk_ovf(stk_ovf), .second_q(second_q)
);

// File: tb/pseq_top_tb_top.sv
module pseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] instr;
  logic        skip_req;
  logic [2:0]  page;
  logic [12:0] fetch_addr;
  logic        stk_ovf;

  logic [12:0] mem [1024];
  logic        skip_en;
  logic [12:0] skip_at;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign instr    = mem[fetch_addr[9:0]];
  assign skip_req = skip_en && (fetch_addr == skip_at);

  pseq_top dut_i (
    .clk(clk), .rst(rst), .instr(instr), .skip_req(skip_req), .page(page),
    .fetch_addr(fetch_addr), .stk_ovf(stk_ovf)
  );

  task automatic chk(input logic [12:0] act, input logic [12:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_chk(input logic [12:0] exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(fetch_addr, exp, tag);
  endtask

  task automatic restart(input logic [2:0] pg);
    for (int i = 0; i < 1024; i++) mem[i] = 13'h0000;
    skip_en = 1'b0;
    skip_at = '0;
    page    = pg;
    rst     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    restart(3'd0);
    chk(fetch_addr, 13'h0, "R1 pc");
    chk({12'h0, stk_ovf}, 13'h0, "R1 ovf");
  endtask

  task automatic t_seq();
    restart(3'd4);
    step_chk(13'h1, "R2");
    step_chk(13'h2, "R2");
    step_chk(13'h3, "R2");
  endtask

  task automatic t_jump();
    restart(3'd0);
    mem[2] = 13'h1555;
    page = 3'd5;
    step_chk(13'h1, "R2");
    step_chk(13'h2, "R2");
    step_chk(13'h1555, "R3");
    step_chk(13'h1556, "R3");
  endtask

  task automatic t_call_ret();
    restart(3'd2);
    mem[1] = 13'h1040;
    mem[13'h040] = 13'h1C05;
    step_chk(13'h1, "R2");
    step_chk(13'h840, "R4");
    step_chk(13'h2, "R6");
    step_chk(13'h3, "R6");
  endtask

  task automatic t_lcall();
    restart(3'd7);
    mem[3] = 13'h1EA5;
    mem[4] = 13'h0123;
    mem[13'h323] = 13'h1C00;
    step_chk(13'h1, "R2");
    step_chk(13'h2, "R2");
    step_chk(13'h3, "R2");
    step_chk(13'h4, "R5 second word");
    step_chk(13'hB23, "R5 target");
    step_chk(13'h5, "R5 return past second word");
  endtask

  task automatic t_ljmp();
    restart(3'd6);
    mem[1] = 13'h1EBF;
    mem[2] = 13'h01FF;
    step_chk(13'h1, "R2");
    step_chk(13'h2, "R7 second word");
    step_chk(13'h1FFF, "R7 target");
    step_chk(13'h0000, "R7 wrap");
  endtask

  task automatic t_skip_one();
    restart(3'd1);
    mem[2] = 13'h1555;
    skip_en = 1'b1;
    skip_at = 13'h2;
    step_chk(13'h1, "R2");
    step_chk(13'h2, "R8");
    step_chk(13'h3, "R8 jump ignored");
  endtask

  task automatic t_skip_two();
    restart(3'd0);
    mem[2] = 13'h1EB2;
    mem[3] = 13'h0007;
    skip_en = 1'b1;
    skip_at = 13'h2;
    step_chk(13'h1, "R2");
    step_chk(13'h2, "R9");
    step_chk(13'h4, "R9 both skipped");
  endtask

  task automatic t_skip_second();
    restart(3'd0);
    mem[1] = 13'h1EB1;
    mem[2] = 13'h0010;
    skip_en = 1'b1;
    skip_at = 13'h2;
    step_chk(13'h1, "R10");
    step_chk(13'h2, "R10");
    step_chk(13'h210, "R10 skip ignored on second word");
  endtask

  task automatic t_overflow();
    restart(3'd0);
    for (int i = 0; i < 9; i++) mem[i * 16] = 13'h1000 | 13'((i + 1) * 16);
    mem[13'h90] = 13'h1C00;
    mem[13'h81] = 13'h1C00;
    for (int i = 0; i < 9; i++) begin
      step_chk(13'((i + 1) * 16), "R11 call chain");
      if (i == 7) chk({12'h0, stk_ovf}, 13'h0, "R11 eight pushes no overflow");
    end
    chk({12'h0, stk_ovf}, 13'h1, "R11 ninth push overflows");
    step_chk(13'h81, "R11 newest entry kept");
    step_chk(13'h71, "R11 next entry");
    chk({12'h0, stk_ovf}, 13'h1, "R11 flag sticky");
  endtask

  initial begin
    rst = 1'b1;
    skip_en = 1'b0;
    skip_at = '0;
    page = '0;
    t_reset();
    t_seq();
    t_jump();
    t_call_ret();
    t_lcall();
    t_ljmp();
    t_skip_one();
    t_skip_two();
    t_skip_second();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule